// File: doc/BRIEF.md
# Parallel-to-Serial Transmit Lane Group with Output-Enable Shaping

The block turns one parallel word per lane into a serial bit stream, one unit interval (UI) per clock, for a group of lanes that share a common phase. The number of UIs per word can be full, half or quarter of the word width. The block reports the cycle in which it captures the next set of words on `word_strobe`. Each lane also drives an output-enable (tristate) signal. It takes that signal from one of two sources. The first is a per-lane direct input, passed through without a register. The second is a small enable vector shared by all lanes. That vector is captured with the data, inverted, and spread over the word at two UIs per bit, so the tristate stays in step with the serial data.

The same shared vector can also act as a transmit gate. When gating is on, a zero in the non-inverted serialized vector replaces the lane's data with the lane's idle level for those UIs. One lane is exempt and is never gated. The group reset and each lane's own reset drive the serial outputs to their idle levels and the tristates to the idle tristate level. After a lane reset is released, that lane stays idle until the next word boundary.

Top module: `txser_top`

## Requirements
- R1: Each lane sends bit 0 of its captured word first and then the higher bits, one per clock. The UI count per word follows `width_sel`: 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2, and 2'b11 is treated as 8.
- R2: `word_strobe` is high for exactly one cycle every UI-count cycles. Its first assertion is in the first cycle after the group reset drops. Data and the enable vector are captured at the rising edge that ends a strobe cycle, and bit 0 appears on `ser_out` after that edge.
- R3: A lane whose `tri_src` bit is 0 drives `tri_out` equal to its `t_in` bit in the same cycle, unless that lane is in reset.
- R4: A lane whose `tri_src` bit is 1 drives the inverse of the captured enable bit, registered and aligned with its data. In 8-UI mode, bit j covers UIs 2j and 2j+1. In 4-UI mode, bit 0 covers UIs 0 and 1 and bit 2 covers UIs 2 and 3.
- R5: In 2-UI mode, a lane with `tri_src` 1 drives `init_tri` on `tri_out`, and gating has no effect.
- R6: With `gate_en` at 1, a lane drives its `init_out` bit instead of data in every UI whose enable bit is 0. In UIs whose enable bit is 1, it sends data.
- R7: Lane 1 is never gated.
- R8: While `rst` is high, every `ser_out` bit equals its `init_out` bit from the next edge on. Every `tri_out` bit equals `init_tri`.
- R9: A lane reset forces only that lane to `init_out` and `init_tri`. After release, the lane stays at those values until the next word boundary.
- R10: Changes to `d` or `wen` after the capture edge do not affect the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UI-rate clock |
| rst | input | 1 | Synchronous group reset, active high |
| slice_rst | input | NS | Per-lane synchronous reset |
| width_sel | input | 2 | UI-count selector |
| tri_src | input | NS | Tristate source per lane: 1 = enable vector, 0 = direct |
| gate_en | input | 1 | Enables transmit gating |
| init_out | input | NS | Idle level for each serial output |
| init_tri | input | 1 | Idle tristate level |
| d | input | NS*WORD_W | Parallel words, lane s in bits [s*WORD_W +: WORD_W] |
| wen | input | WORD_W/2 | Shared enable vector |
| t_in | input | NS | Direct tristate inputs |
| word_strobe | output | 1 | High in the cycle whose closing edge captures inputs |
| ser_out | output | NS | Serial data per lane |
| tri_out | output | NS | Tristate control per lane |

## Verification
The hardest case to reach from the ports is a lane reset released in the middle of a word. The block keeps sending, so the released lane has to stay idle while its neighbours carry data. The stimulus raises one lane's reset at a word boundary, holds it across the next capture edge, and drops it at UI 3. It then expects the idle level until the following boundary. The other hard point is a gated UI that falls on a 2-UI enable bit. Fixed enable patterns of alternating and all-zero bits are used with gating on in both 8-UI and 4-UI modes. The inputs are then scrambled right after each capture edge to show that capture is word-aligned.

// File: rtl/txser_pkg.sv
package txser_pkg;

  typedef enum logic [1:0] {
    UI_FULL    = 2'b00,
    UI_HALF    = 2'b01,
    UI_QUARTER = 2'b10,
    UI_RSVD    = 2'b11
  } ui_mode_e;

  // UIs carried per word for a given selector; reserved code acts as full
  function automatic int unsigned ui_per_word(input logic [1:0] sel,
                                              input int unsigned full);
    case (sel)
      UI_HALF:    return full / 2;
      UI_QUARTER: return full / 4;
      default:    return full;
    endcase
  endfunction

endpackage

// File: rtl/txser_phase.sv
module txser_phase #(
  parameter int WORD_W = 8,
  parameter int PH_W   = $clog2(WORD_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      width_sel,
  output logic [PH_W-1:0] ph,
  output logic            at_start
);
  logic [PH_W-1:0] last_ph;

  assign last_ph  = PH_W'(txser_pkg::ui_per_word(width_sel, WORD_W) - 1);
  assign at_start = (ph == '0) && !rst;

  always_ff @(posedge clk) begin
    if (rst)                ph <= '0;
    else if (ph == last_ph) ph <= '0;
    else                    ph <= ph + 1'b1;
  end
endmodule

// File: rtl/txser_wen.sv
module txser_wen #(
  parameter int WORD_W = 8,
  parameter int WEN_W  = WORD_W / 2,
  parameter int PH_W   = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_start,
  input  logic [PH_W-1:0]  ph,
  input  logic [1:0]       width_sel,
  input  logic [WEN_W-1:0] wen_in,
  output logic             wen_bit,
  output logic             wen_off
);
  logic [WEN_W-1:0] held;
  logic [WEN_W-1:0] src;
  int unsigned      pick;

  always_ff @(posedge clk) begin
    if (rst)           held <= '0;
    else if (at_start) held <= wen_in;
  end

  // first UI of a word reads the vector straight from the input
  assign src     = at_start ? wen_in : held;
  assign wen_off = (width_sel == txser_pkg::UI_QUARTER);

  always_comb begin
    if (width_sel == txser_pkg::UI_HALF) pick = (int'(ph) / 2) * 2;
    else                                 pick = int'(ph) / 2;
    wen_bit = 1'b0;
    for (int j = 0; j < WEN_W; j++)
      if (pick == j) wen_bit = src[j];
  end
endmodule

// File: rtl/txser_lane.sv
module txser_lane #(
  parameter int WORD_W   = 8,
  parameter int PH_W     = $clog2(WORD_W),
  parameter bit GATEABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lane_rst,
  input  logic              at_start,
  input  logic [PH_W-1:0]   ph,
  input  logic [WORD_W-1:0] word,
  input  logic              wen_bit,
  input  logic              wen_off,
  input  logic              gate_en,
  input  logic              use_wen,
  input  logic              init_o,
  input  logic              init_t,
  input  logic              t_direct,
  output logic              ser_o,
  output logic              tri_o
);
  logic [WORD_W-1:0] held;
  logic              armed;
  logic              live;
  logic              act;
  logic              blocked;
  logic              cur_bit;
  logic              ser_q;
  logic              tz_q;

  assign live    = !(rst || lane_rst);
  assign act     = live && (at_start || armed);
  assign cur_bit = at_start ? word[0] : held[ph];
  assign blocked = GATEABLE && gate_en && !wen_off && !wen_bit;

  always_ff @(posedge clk) begin
    if (at_start) held <= word;
  end

  // a lane released mid-word waits for the next boundary
  always_ff @(posedge clk) begin
    if (!live)         armed <= 1'b0;
    else if (at_start) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    ser_q <= (!act || blocked) ? init_o : cur_bit;
    tz_q  <= (!act || wen_off) ? init_t : !wen_bit;
  end

  assign ser_o = ser_q;
  assign tri_o = use_wen ? tz_q : (live ? t_direct : init_t);
endmodule

// File: rtl/txser_top.sv
module txser_top #(
  parameter int NS          = 6,
  parameter int WORD_W      = 8,
  parameter int EXEMPT_LANE = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NS-1:0]          slice_rst,
  input  logic [1:0]             width_sel,
  input  logic [NS-1:0]          tri_src,
  input  logic                   gate_en,
  input  logic [NS-1:0]          init_out,
  input  logic                   init_tri,
  input  logic [NS*WORD_W-1:0]   d,
  input  logic [WORD_W/2-1:0]    wen,
  input  logic [NS-1:0]          t_in,
  output logic                   word_strobe,
  output logic [NS-1:0]          ser_out,
  output logic [NS-1:0]          tri_out
);
  localparam int PH_W  = $clog2(WORD_W);
  localparam int WEN_W = WORD_W / 2;

  logic [PH_W-1:0] ph;
  logic            at_start;
  logic            wen_bit;
  logic            wen_off;

  txser_phase #(.WORD_W(WORD_W), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .width_sel(width_sel),
    .ph(ph), .at_start(at_start)
  );

  txser_wen #(.WORD_W(WORD_W), .WEN_W(WEN_W), .PH_W(PH_W)) u_wen (
    .clk(clk), .rst(rst), .at_start(at_start), .ph(ph),
    .width_sel(width_sel), .wen_in(wen),
    .wen_bit(wen_bit), .wen_off(wen_off)
  );

  for (genvar s = 0; s < NS; s++) begin : g_lane
    txser_lane #(
      .WORD_W(WORD_W), .PH_W(PH_W), .GATEABLE(s != EXEMPT_LANE)
    ) u_lane (
      .clk(clk), .rst(rst), .lane_rst(slice_rst[s]),
      .at_start(at_start), .ph(ph),
      .word(d[s*WORD_W +: WORD_W]),
      .wen_bit(wen_bit), .wen_off(wen_off), .gate_en(gate_en),
      .use_wen(tri_src[s]), .init_o(init_out[s]), .init_t(init_tri),
      .t_direct(t_in[s]), .ser_o(ser_out[s]), .tri_o(tri_out[s])
    );
  end

  assign word_strobe = at_start;
endmodule

// File: rtl/txser_checker.sv
module txser_checker #(
  parameter int NS     = 6,
  parameter int WORD_W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [NS-1:0] slice_rst,
  input logic [1:0]    width_sel,
  input logic [NS-1:0] tri_src,
  input logic [NS-1:0] init_out,
  input logic          init_tri,
  input logic [NS-1:0] t_in,
  input logic          word_strobe,
  input logic [NS-1:0] ser_out,
  input logic [NS-1:0] tri_out
);
  localparam int CW = $clog2(WORD_W) + 2;

  logic [CW-1:0] since;
  logic          seen;
  logic [CW-1:0] ui_n;

  assign ui_n = CW'(txser_pkg::ui_per_word(width_sel, WORD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (word_strobe) begin
      since <= CW'(1);
      seen  <= 1'b1;
    end else if (since < ui_n) begin
      since <= since + 1'b1;
    end
  end

  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
    seen |-> (word_strobe == (since == ui_n)));

  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (ser_out == $past(init_out)));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    assert_direct_tri_R3: assert property (@(posedge clk) disable iff (rst)
      (!tri_src[s] && !slice_rst[s]) |-> (tri_out[s] == t_in[s]));

    assert_quarter_tri_R5: assert property (@(posedge clk) disable iff (rst)
      (width_sel == 2'b10 && $stable(width_sel) && $stable(init_tri) && tri_src[s])
        |-> (tri_out[s] == init_tri));

    assert_lane_idle_R9: assert property (@(posedge clk) disable iff (rst)
      $past(slice_rst[s]) |-> (ser_out[s] == $past(init_out[s])));
  end
endmodule

bind txser_top txser_checker #(.NS(NS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .slice_rst(slice_rst), .width_sel(width_sel),
  .tri_src(tri_src), .init_out(init_out), .init_tri(init_tri),
  .t_in(t_in), .word_strobe(word_strobe), .ser_out(ser_out),
  .tri_out(tri_out)
);

// File: tb/tb_txser_top.sv
module tb_txser_top;
  localparam int NS = 6;
  localparam int WW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   slice_rst = '0;
  logic [1:0]      width_sel = 2'b00;
  logic [NS-1:0]   tri_src = '0;
  logic            gate_en = 1'b0;
  logic [NS-1:0]   init_out = '0;
  logic            init_tri = 1'b1;
  logic [NS*WW-1:0] d = '0;
  logic [WW/2-1:0] wen = '0;
  logic [NS-1:0]   t_in = '0;
  logic            word_strobe;
  logic [NS-1:0]   ser_out;
  logic [NS-1:0]   tri_out;

  int checks = 0;
  int failures = 0;
  int cfg_w = 8;
  bit done = 1'b0;

  typedef struct {
    logic [NS-1:0] ser_v;
    logic [NS-1:0] tz_v;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  txser_top #(.NS(NS), .WORD_W(WW)) dut (
    .clk(clk), .rst(rst), .slice_rst(slice_rst), .width_sel(width_sel),
    .tri_src(tri_src), .gate_en(gate_en), .init_out(init_out),
    .init_tri(init_tri), .d(d), .wen(wen), .t_in(t_in),
    .word_strobe(word_strobe), .ser_out(ser_out), .tri_out(tri_out)
  );

  task automatic expect_eq(input string tag, input logic [NS-1:0] act,
                           input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pop one expected UI and compare
  task automatic monitor_ui();
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      expect_eq({e.tag, " ser"}, ser_out, e.ser_v);
      expect_eq({e.tag, " tri"}, tri_out, e.tz_v);
    end
  endtask

  // driver: capture-time stimulus turned into cfg_w expected UIs
  task automatic push_word(input string tag, input logic [NS-1:0] fm);
    for (int k = 0; k < cfg_w; k++) begin
      exp_t e;
      logic wb;
      wb = (cfg_w == 8) ? wen[k/2] : wen[(k/2)*2];
      for (int s = 0; s < NS; s++) begin
        logic blk;
        blk = gate_en && (s != 1) && (cfg_w != 2) && !wb;
        e.ser_v[s] = (fm[s] || blk) ? init_out[s] : d[s*WW + k];
        if (fm[s])            e.tz_v[s] = init_tri;
        else if (tri_src[s])  e.tz_v[s] = (cfg_w == 2) ? init_tri : !wb;
        else                  e.tz_v[s] = t_in[s];
      end
      e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic do_word(input string tag, input logic [WW/2-1:0] wp,
                         input logic [NS-1:0] fm, input int rel_k);
    slice_rst = fm;
    wen = wp;
    for (int s = 0; s < NS; s++) d[s*WW +: WW] = WW'($urandom);
    push_word(tag, fm);
    for (int k = 1; k < cfg_w; k++) begin
      @(negedge clk);
      monitor_ui();
      #1;
      expect_eq("R2 strobe low mid-word", NS'(word_strobe), '0);
      if (k == 1) begin  // R10: late changes must be ignored
        for (int s = 0; s < NS; s++) d[s*WW +: WW] = WW'($urandom);
        wen = ~wp;
      end
      if (k == rel_k) slice_rst = '0;
    end
    @(negedge clk);
    monitor_ui();
    #1;
    expect_eq("R2 strobe at boundary", NS'(word_strobe), NS'(1));
  endtask

  task automatic reconf(input logic [1:0] code, input logic [NS-1:0] src,
                        input logic g, input logic [NS-1:0] io, input logic it);
    rst = 1'b1;
    width_sel = code;
    tri_src = src;
    gate_en = g;
    init_out = io;
    init_tri = it;
    wen = '0;
    slice_rst = '0;
    t_in = {NS{~it}};
    cfg_w = (code == 2'b01) ? 4 : (code == 2'b10) ? 2 : 8;
    @(negedge clk);
    #1;
    expect_eq("R8 reset ser", ser_out, io);
    expect_eq("R8 reset tri", tri_out, {NS{it}});
    expect_eq("R2 no strobe in reset", NS'(word_strobe), '0);
    @(negedge clk);
    rst = 1'b0;
    t_in = NS'($urandom);
    #1;
    expect_eq("R2 strobe after reset", NS'(word_strobe), NS'(1));
  endtask

  task automatic direct_probe();
    logic [NS-1:0] keep;
    keep = t_in;
    t_in = ~keep;
    #1;
    for (int s = 0; s < NS; s++)
      if (!tri_src[s]) expect_eq("R3 direct tri", NS'(tri_out[s]), NS'(t_in[s]));
    t_in = keep;
    #1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 R4: 8 UI, mixed sources
    reconf(2'b00, 6'b101010, 1'b0, 6'b110011, 1'b1);
    direct_probe();
    do_word("R1/R4 w8", 4'b0110, '0, -1);
    do_word("R1/R4 w8", 4'b1001, '0, -1);
    do_word("R10 w8", 4'b0011, '0, -1);
    // R6 R7: gating at 8 UI
    reconf(2'b00, 6'b111111, 1'b1, 6'b010101, 1'b0);
    do_word("R6/R7 gate w8", 4'b0101, '0, -1);
    do_word("R6/R7 gate w8", 4'b0000, '0, -1);
    do_word("R6/R7 gate w8", 4'b1110, '0, -1);
    // R4 R6: 4 UI uses bits 0 and 2
    reconf(2'b01, 6'b110101, 1'b1, 6'b101101, 1'b1);
    direct_probe();
    do_word("R4/R6 w4", 4'b1010, '0, -1);
    do_word("R4/R6 w4", 4'b0101, '0, -1);
    do_word("R4/R6 w4", 4'b1011, '0, -1);
    // R5: 2 UI, enable tristate and gating inert
    reconf(2'b10, 6'b111111, 1'b1, 6'b000111, 1'b0);
    do_word("R5 w2", 4'b0000, '0, -1);
    do_word("R5 w2", 4'b1111, '0, -1);
    do_word("R1 w2", 4'b0000, '0, -1);
    // R1: reserved selector acts as 8 UI
    reconf(2'b11, 6'b000000, 1'b0, 6'b111000, 1'b1);
    do_word("R1 sel11", 4'b1111, '0, -1);
    do_word("R1 sel11", 4'b0110, '0, -1);
    // R9: lane reset, released mid-word
    reconf(2'b00, 6'b111111, 1'b0, 6'b011110, 1'b1);
    do_word("R9 before", 4'b0110, '0, -1);
    do_word("R9 held", 4'b1001, 6'b001000, -1);
    do_word("R9 released", 4'b0101, 6'b001000, 3);
    do_word("R9 after", 4'b1100, '0, -1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule